// File: doc/BRIEF.md
# PTP Event Frame Timestamp Unit

This block sits on one direction of an Ethernet media-independent interface, either receive or transmit. It follows the frame stream and finds the start-of-frame delimiter. It latches the value of an external real-time clock at the first data unit after that delimiter. It then parses the frame as a layer-2 PTP message. When the frame is a PTP message whose id is enabled in a software-written mask, the unit pushes one 128-bit record into a 16-deep queue. The record holds the captured seconds and nanoseconds, the message id, a 12-bit header checksum and the sequence id.

The data path runs either as 8-bit GMII (one byte per cycle) or as 4-bit MII (two nibbles per byte, low nibble first). The `gmii_mode` pin selects the width. The line stream has no back-pressure: bytes arrive whenever `line_dv` is high. When the queue is full, a new record is dropped and a sticky overflow flag is set. A CPU drains the queue through a small register window. Each instance decodes its own address block starting at `BASE_ADDR`, so a receive instance and a transmit instance can share one bus. Addresses count bytes by default; a parameter switches them to 32-bit word units.

Register words, relative to the block base: 0..3 hold the head record from bits 127:96 down to 31:0, and reading word 3 pops the record. Word 4 is status, with overflow in bit 31 and the record count in the low bits; reading it clears the overflow flag. Word 5 is the message-id mask in bits 15:0.

Top module: `ptp_tsu`

## Requirements
- R1: In GMII mode, with `line_d` sampled while `line_dv` is high, the byte 0xD5 that follows the preamble starts a frame. The next byte is frame byte 0.
- R2: In MII mode, nibbles arrive on `line_d[3:0]`, low nibble first. Byte alignment is taken from the delimiter itself, so an odd or even count of preamble nibbles gives the same records.
- R3: The captured timestamp is the `rtc_sec`/`rtc_ns` value presented during the cycle that carries the first data unit after the delimiter.
- R4: A frame is a PTP candidate only if frame bytes 12 and 13 hold 0x88 and 0xF7. Any other type value produces no record.
- R5: The message id is the low nibble of frame byte 14. A record is produced only if mask bit [id] is set. The mask resets to 0x000F and is written at word 5 (bits 15:0).
- R6: A record is, from bit 127 down: 16 zero bits, 48-bit seconds, 32-bit nanoseconds, 4-bit message id, 12-bit checksum, 16-bit sequence id.
- R7: The checksum is the sum of frame bytes 14 to 47, modulo 4096. The sequence id is frame byte 44 (high) followed by frame byte 45 (low).
- R8: A frame whose `line_dv` drops before frame byte 47 produces no record.
- R9: Records leave in arrival order. A record arriving at a full queue (16 entries) is dropped and sets the status overflow bit 31. That bit stays set until status is read, and the read itself returns it set.
- R10: Words 0..3 return the head record, most significant word first, and a read of word 3 pops it. With the queue empty, these words read as zero and nothing is popped.
- R11: In byte addressing the word index is (address − BASE_ADDR)/4; in word addressing it is address − BASE_ADDR. Addresses outside the eight-word block read zero, and writes to them are ignored.
- R12: A record committed in the same cycle as a pop of another record is kept, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by line, clock value and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| gmii_mode | input | 1 | 1: byte path, 0: nibble path |
| line_dv | input | 1 | Line data valid, high for the whole frame |
| line_d | input | 8 | Line data; only bits 3:0 are used in nibble mode |
| rtc_sec | input | 48 | Real-time clock seconds |
| rtc_ns | input | 32 | Real-time clock nanoseconds |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Read data, combinational from address |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Write data (mask bits) |

## Verification
A frame can commit its record in exactly the cycle in which the CPU reads word 3 and pops the current head, so a push and a pop land together. The bench first leaves one record queued. It then starts a new frame and, in parallel, schedules the word-3 read onto the cycle that carries frame byte 47. The popped value must equal the older record, the status count must stay at one, and the next drain must return the new frame's record with the timestamp and fields the bench predicted.

// File: rtl/ptp_tsu_pkg.sv
package ptp_tsu_pkg;

  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [15:0] PTP_ETYPE  = 16'h88F7;
  localparam int          ETYPE_POS  = 12;
  localparam int          HDR_POS    = 14;
  localparam int          HDR_LEN    = 34;
  localparam int          SEQ_REL    = 30;
  localparam int          MASK_W     = 16;

  typedef struct packed {
    logic [15:0] pad;
    logic [47:0] sec;
    logic [31:0] ns;
    logic [3:0]  msg_id;
    logic [11:0] csum;
    logic [15:0] seq;
  } tsu_entry_t;

  typedef enum logic [1:0] {
    PS_HUNT  = 2'd0,
    PS_FRAME = 2'd1,
    PS_DONE  = 2'd2
  } parse_st_e;

endpackage

// File: rtl/tsu_nibble_pack.sv
module tsu_nibble_pack
  import ptp_tsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gmii_mode,
  input  logic       line_dv,
  input  logic [7:0] line_d,
  output logic       byte_vld,
  output logic [7:0] byte_d
);

  logic [3:0] lo_q;
  logic       locked_q;
  logic       phase_q;
  logic [7:0] pair;

  assign pair = {line_d[3:0], lo_q};

  always_comb begin
    if (gmii_mode) begin
      byte_vld = line_dv;
      byte_d   = line_d;
    end else if (!locked_q) begin
      byte_vld = line_dv;
      byte_d   = pair;
    end else begin
      byte_vld = line_dv && phase_q;
      byte_d   = pair;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      locked_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (!line_dv) begin
      locked_q <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      lo_q <= line_d[3:0];
      if (!gmii_mode && !locked_q && pair == SFD_BYTE) begin
        locked_q <= 1'b1;
        phase_q  <= 1'b0;
      end else if (locked_q) begin
        phase_q <= ~phase_q;
      end
    end
  end

  // R2
  mii_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gmii_mode && locked_q && phase_q && byte_vld) |=> (!byte_vld || gmii_mode));

endmodule

// File: rtl/tsu_frame_parse.sv
module tsu_frame_parse
  import ptp_tsu_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dv,
  input  logic              byte_vld,
  input  logic [7:0]        byte_d,
  input  logic [SEC_W-1:0]  rtc_sec,
  input  logic [NS_W-1:0]   rtc_ns,
  input  logic [MASK_W-1:0] id_mask,
  output logic              push,
  output tsu_entry_t        entry
);

  localparam int LAST_POS = HDR_POS + HDR_LEN - 1;
  localparam int IDX_W    = $clog2(LAST_POS + 1);
  localparam logic [IDX_W-1:0] I_ET_HI = IDX_W'(ETYPE_POS);
  localparam logic [IDX_W-1:0] I_ET_LO = IDX_W'(ETYPE_POS + 1);
  localparam logic [IDX_W-1:0] I_HDR   = IDX_W'(HDR_POS);
  localparam logic [IDX_W-1:0] I_SEQ_H = IDX_W'(HDR_POS + SEQ_REL);
  localparam logic [IDX_W-1:0] I_SEQ_L = IDX_W'(HDR_POS + SEQ_REL + 1);
  localparam logic [IDX_W-1:0] I_LAST  = IDX_W'(LAST_POS);

  parse_st_e        st;
  logic [IDX_W-1:0] idx;
  logic             cap_pend;
  logic [SEC_W-1:0] ts_sec;
  logic [NS_W-1:0]  ts_ns;
  logic [7:0]       et_hi;
  logic             is_ptp;
  logic [3:0]       msg_id;
  logic [11:0]      csum;
  logic [15:0]      seq;
  logic             at_last;

  assign at_last = (st == PS_FRAME) && byte_vld && (idx == I_LAST);
  assign push    = at_last && is_ptp && id_mask[msg_id];

  always_comb begin
    entry        = '0;
    entry.sec    = ts_sec;
    entry.ns     = ts_ns;
    entry.msg_id = msg_id;
    entry.csum   = csum + {4'h0, byte_d};
    entry.seq    = seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PS_HUNT;
      idx      <= '0;
      cap_pend <= 1'b0;
      ts_sec   <= '0;
      ts_ns    <= '0;
      et_hi    <= '0;
      is_ptp   <= 1'b0;
      msg_id   <= '0;
      csum     <= '0;
      seq      <= '0;
    end else if (!line_dv) begin
      st       <= PS_HUNT;
      cap_pend <= 1'b0;
    end else begin
      unique case (st)
        PS_HUNT: begin
          if (byte_vld && byte_d == SFD_BYTE) begin
            st       <= PS_FRAME;
            idx      <= '0;
            cap_pend <= 1'b1;
            is_ptp   <= 1'b0;
            csum     <= '0;
          end
        end
        PS_FRAME: begin
          if (cap_pend) begin
            ts_sec   <= rtc_sec;
            ts_ns    <= rtc_ns;
            cap_pend <= 1'b0;
          end
          if (byte_vld) begin
            idx <= idx + 1'b1;
            if (idx == I_ET_HI) et_hi <= byte_d;
            if (idx == I_ET_LO) is_ptp <= ({et_hi, byte_d} == PTP_ETYPE);
            if (idx >= I_HDR)   csum <= csum + {4'h0, byte_d};
            if (idx == I_HDR)   msg_id <= byte_d[3:0];
            if (idx == I_SEQ_H) seq[15:8] <= byte_d;
            if (idx == I_SEQ_L) seq[7:0] <= byte_d;
            if (idx == I_LAST)  st <= PS_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  ts_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_FRAME && !cap_pend && line_dv) |=> ($stable(ts_sec) && $stable(ts_ns)));

  // R8
  push_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (st == PS_DONE));

endmodule

// File: rtl/tsu_entry_fifo.sv
module tsu_entry_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  input  logic             clr_ovf,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, accept, take;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign accept = push && !full;
  assign take   = pop && !empty;
  assign dout   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (take)   rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      if (accept && !take)      count <= count + 1'b1;
      else if (take && !accept) count <= count - 1'b1;
      if (push && full)  overflow <= 1'b1;
      else if (clr_ovf)  overflow <= 1'b0;
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow);

  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R12
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full) |=> (count == $past(count)));

endmodule

// File: rtl/tsu_csr.sv
module tsu_csr
  import ptp_tsu_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h40,
  parameter bit              ADDR_IS_WORD = 1'b0,
  parameter int              CNT_W        = 5,
  parameter logic [MASK_W-1:0] MASK_RST   = 16'h000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MASK_W-1:0] wr_data,
  input  tsu_entry_t        head,
  input  logic              empty,
  input  logic [CNT_W-1:0]  count,
  input  logic              overflow,
  output logic              pop,
  output logic              clr_ovf,
  output logic [MASK_W-1:0] id_mask
);

  localparam int NWORDS = 8;
  localparam int SHIFT  = ADDR_IS_WORD ? 0 : 2;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NWORDS << SHIFT);
  localparam logic [2:0] W_STAT = 3'd4;
  localparam logic [2:0] W_MASK = 3'd5;
  localparam logic [2:0] W_POP  = 3'd3;

  logic              r_hit, w_hit;
  logic [2:0]        r_word, w_word;
  logic [ADDR_W-1:0] r_off, w_off;

  // Address unit picked by parameter: word units use the offset as-is.
  generate
    if (ADDR_IS_WORD) begin : g_word_addr
      assign r_word = r_off[2:0];
      assign w_word = w_off[2:0];
    end else begin : g_byte_addr
      assign r_word = r_off[4:2];
      assign w_word = w_off[4:2];
    end
  endgenerate

  assign r_off = rd_addr - BASE_ADDR;
  assign w_off = wr_addr - BASE_ADDR;
  assign r_hit = (rd_addr >= BASE_ADDR) && (r_off < SPAN);
  assign w_hit = (wr_addr >= BASE_ADDR) && (w_off < SPAN);

  logic [127:0] head_bits;
  assign head_bits = empty ? '0 : head;

  always_comb begin
    rd_data = '0;
    if (r_hit) begin
      unique case (r_word)
        3'd0:   rd_data = head_bits[127:96];
        3'd1:   rd_data = head_bits[95:64];
        3'd2:   rd_data = head_bits[63:32];
        3'd3:   rd_data = head_bits[31:0];
        W_STAT: rd_data = {overflow, {(31 - CNT_W){1'b0}}, count};
        W_MASK: rd_data = {{(32 - MASK_W){1'b0}}, id_mask};
        default: rd_data = '0;
      endcase
    end
  end

  assign pop     = rd_en && r_hit && (r_word == W_POP) && !empty;
  assign clr_ovf = rd_en && r_hit && (r_word == W_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)                                 id_mask <= MASK_RST;
    else if (wr_en && w_hit && w_word == W_MASK) id_mask <= wr_data;
  end

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_hit) |=> $stable(id_mask));

endmodule

// File: rtl/ptp_tsu.sv
module ptp_tsu
  import ptp_tsu_pkg::*;
#(
  parameter int                DEPTH        = 16,
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 8'h40,
  parameter bit                ADDR_IS_WORD = 1'b0,
  parameter logic [15:0]       MASK_RST     = 16'h000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gmii_mode,
  input  logic              line_dv,
  input  logic [7:0]        line_d,
  input  logic [47:0]       rtc_sec,
  input  logic [31:0]       rtc_ns,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int ENT_W = $bits(tsu_entry_t);

  logic             byte_vld;
  logic [7:0]       byte_d;
  logic             push, pop, clr_ovf, empty, overflow;
  tsu_entry_t       new_entry, head;
  logic [ENT_W-1:0] head_raw;
  logic [CNT_W-1:0] count;
  logic [15:0]      id_mask;

  assign head = tsu_entry_t'(head_raw);

  tsu_nibble_pack u_pack (
    .clk(clk), .rst_n(rst_n), .gmii_mode(gmii_mode),
    .line_dv(line_dv), .line_d(line_d),
    .byte_vld(byte_vld), .byte_d(byte_d)
  );

  tsu_frame_parse #(.SEC_W(48), .NS_W(32)) u_parse (
    .clk(clk), .rst_n(rst_n), .line_dv(line_dv),
    .byte_vld(byte_vld), .byte_d(byte_d),
    .rtc_sec(rtc_sec), .rtc_ns(rtc_ns), .id_mask(id_mask),
    .push(push), .entry(new_entry)
  );

  tsu_entry_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(new_entry),
    .pop(pop), .clr_ovf(clr_ovf), .dout(head_raw),
    .count(count), .empty(empty), .overflow(overflow)
  );

  tsu_csr #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ADDR_IS_WORD(ADDR_IS_WORD),
    .CNT_W(CNT_W), .MASK_RST(MASK_RST)
  ) u_csr (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .head(head), .empty(empty), .count(count), .overflow(overflow),
    .pop(pop), .clr_ovf(clr_ovf), .id_mask(id_mask)
  );

endmodule

// File: tb/sim_ptp_tsu.sv
module sim_ptp_tsu;

  localparam int CLK_NS = 10;
  localparam logic [7:0] B0 = 8'h40;
  localparam logic [7:0] B1 = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gmii_mode = 1'b1;
  logic        line_dv = 1'b0;
  logic [7:0]  line_d = '0;
  logic [47:0] rtc_sec = '0;
  logic [31:0] rtc_ns;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] rd_data0, rd_data1;

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) rtc_ns <= 32'h0000_0100;
    else        rtc_ns <= rtc_ns + 1;
  end

  ptp_tsu u0 (
    .clk(clk), .rst_n(rst_n), .gmii_mode(gmii_mode), .line_dv(line_dv), .line_d(line_d),
    .rtc_sec(rtc_sec), .rtc_ns(rtc_ns), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data0),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ptp_tsu #(.BASE_ADDR(B1), .ADDR_IS_WORD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .gmii_mode(gmii_mode), .line_dv(line_dv), .line_d(line_d),
    .rtc_sec(rtc_sec), .rtc_ns(rtc_ns), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0]   fb [0:63];
  logic [127:0] sb [$];
  int           model_cnt = 0;
  logic [15:0]  model_mask = 16'h000F;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input bit sel1, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = sel1 ? rd_data1 : rd_data0;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic build(input logic [3:0] id, input logic [15:0] seq, input logic [15:0] et, input logic [7:0] salt);
    for (int i = 0; i < 64; i++) fb[i] = 8'(salt + 8'(i * 7));
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = {4'h2, id};
    fb[44] = seq[15:8]; fb[45] = seq[7:0];
  endtask

  task automatic nib(input logic [3:0] n);
    @(negedge clk); line_dv = 1'b1; line_d = {4'h0, n};
  endtask

  task automatic send(input bit gm, input int nb, input bit oddp, output logic [31:0] ts);
    ts = '0;
    gmii_mode = gm;
    if (gm) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); line_dv = 1'b1; line_d = (i == 7) ? 8'hD5 : 8'h55;
      end
      for (int i = 0; i < nb; i++) begin
        @(negedge clk); line_d = fb[i];
        if (i == 0) ts = rtc_ns;
      end
    end else begin
      for (int i = 0; i < (oddp ? 13 : 14); i++) nib(4'h5);
      nib(4'h5); nib(4'hD);
      for (int i = 0; i < nb; i++) begin
        nib(fb[i][3:0]);
        if (i == 0) ts = rtc_ns;
        nib(fb[i][7:4]);
      end
    end
    @(negedge clk); line_dv = 1'b0; line_d = '0;
    repeat (4) @(negedge clk);
  endtask

  // Driver side of the scoreboard: predicts the record from the requirements.
  task automatic expect_rec(input int nb, input logic [31:0] ts);
    logic [11:0] cs = '0;
    logic [3:0]  id = fb[14][3:0];
    for (int i = 14; i < 48; i++) cs = cs + 12'(fb[i]);
    if ({fb[12], fb[13]} == 16'h88F7 && model_mask[id] && nb >= 48) begin
      if (model_cnt < 16) begin
        sb.push_back({16'h0, rtc_sec, ts, id, cs, fb[44], fb[45]});
        model_cnt++;
      end
    end
  endtask

  // Monitor side: drains the queue and compares against predictions.
  task automatic drain(input string req);
    logic [31:0] st, w0, w1, w2, w3;
    logic [127:0] exp;
    rd(B0 + 8'd16, 1'b0, st);
    chk(st[4:0] == 5'(model_cnt), req, st, model_cnt);
    while (model_cnt > 0) begin
      rd(B0 + 8'd0, 1'b0, w0); rd(B0 + 8'd4, 1'b0, w1);
      rd(B0 + 8'd8, 1'b0, w2); rd(B0 + 8'd12, 1'b0, w3);
      exp = sb.pop_front();
      model_cnt--;
      chk({w0, w1, w2, w3} == exp, req, {w0, w1, w2, w3}, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, ts, tsb;
    logic [127:0] exp_a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    rd(B0 + 8'd16, 1'b0, v); chk(v == 32'h0, "R9 reset status", v, 0);
    rd(B0 + 8'd20, 1'b0, v); chk(v == 32'h000F, "R5 reset mask", v, 32'h000F);
    rd(B0 + 8'd0, 1'b0, v);  chk(v == 32'h0, "R10 empty read", v, 0);
    rd(B0 + 8'd12, 1'b0, v); chk(v == 32'h0, "R10 empty word3", v, 0);

    // R1 R3 R6 R7: byte path
    rtc_sec = 48'h0000_1234_5678;
    build(4'h0, 16'h1234, 16'h88F7, 8'h11); send(1'b1, 52, 1'b0, ts); expect_rec(52, ts);
    drain("R1 R3 R6 R7 gmii");

    // R2: nibble path, even and odd preamble
    rtc_sec = 48'h0000_0000_0042;
    build(4'h1, 16'hBEEF, 16'h88F7, 8'h23); send(1'b0, 50, 1'b0, ts); expect_rec(50, ts);
    build(4'h3, 16'h0102, 16'h88F7, 8'h5A); send(1'b0, 50, 1'b1, ts); expect_rec(50, ts);
    drain("R2 mii");

    // R5: unmasked id, then mask changed
    build(4'h8, 16'h0808, 16'h88F7, 8'h31); send(1'b1, 48, 1'b0, ts); expect_rec(48, ts);
    drain("R5 id8 masked out");
    wr(B0 + 8'd20, 16'h0100); model_mask = 16'h0100;
    build(4'h8, 16'h0809, 16'h88F7, 8'h32); send(1'b1, 48, 1'b0, ts); expect_rec(48, ts);
    build(4'h0, 16'h0001, 16'h88F7, 8'h33); send(1'b1, 48, 1'b0, ts); expect_rec(48, ts);
    drain("R5 mask write");

    // R4: non-PTP type; R8: truncated frame
    wr(B0 + 8'd20, 16'h000F); model_mask = 16'h000F;
    build(4'h0, 16'h4444, 16'h0800, 8'h44); send(1'b1, 52, 1'b0, ts); expect_rec(52, ts);
    drain("R4 wrong type");
    build(4'h0, 16'h5555, 16'h88F7, 8'h55); send(1'b1, 40, 1'b0, ts); expect_rec(40, ts);
    drain("R8 short frame");

    // R11: out-of-block write, word-addressed instance
    wr(8'h60, 16'hFFFF);
    rd(B0 + 8'd20, 1'b0, v); chk(v == 32'h000F, "R11 out-of-block write", v, 32'h000F);
    rd(8'h60, 1'b0, v);      chk(v == 32'h0, "R11 out-of-block read", v, 0);
    wr(B1 + 8'd5, 16'hABCD);
    rd(B1 + 8'd5, 1'b1, v);  chk(v == 32'hABCD, "R11 word addressing", v, 32'hABCD);
    rd(B0 + 8'd20, 1'b0, v); chk(v == 32'h000F, "R11 blocks separate", v, 32'h000F);

    // R9: overflow after 16 records
    for (int k = 0; k < 17; k++) begin
      rtc_sec = 48'(k + 100);
      build(4'(k % 4), 16'(k * 3 + 1), 16'h88F7, 8'(k * 5));
      send(1'b1, 48, 1'b0, ts); expect_rec(48, ts);
    end
    rd(B0 + 8'd16, 1'b0, v); chk(v == 32'h8000_0010, "R9 full with overflow", v, 32'h8000_0010);
    rd(B0 + 8'd16, 1'b0, v); chk(v == 32'h0000_0010, "R9 overflow cleared", v, 32'h0000_0010);
    drain("R9 fifo order");

    // R12: commit and pop in the same cycle
    rtc_sec = 48'h77;
    build(4'h2, 16'hA0A0, 16'h88F7, 8'h66); send(1'b1, 48, 1'b0, ts); expect_rec(48, ts);
    exp_a = sb[0];
    rtc_sec = 48'h78;
    build(4'h1, 16'hB1B1, 16'h88F7, 8'h77);
    fork
      send(1'b1, 52, 1'b0, tsb);
      begin
        repeat (56) @(negedge clk);
        rd_en = 1'b1; rd_addr = B0 + 8'd12;
        #1 v = rd_data0;
        @(posedge clk); #1 rd_en = 1'b0;
      end
    join
    chk(v == exp_a[31:0], "R12 popped word", v, exp_a[31:0]);
    void'(sb.pop_front()); model_cnt--;
    expect_rec(52, tsb);
    drain("R12 push with pop");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule